// File: doc/BRIEF.md
# Converter Result Serial/Parallel Port

This block hands a finished conversion word to a host over one of two paths. With the port select low it drives the whole word onto a parallel bus, with the two bytes optionally exchanged. With the port select high it turns off the parallel drivers and shifts the word out on a single serial line, most significant bit first, framed by a SYNC level. In both paths a coding select can invert the top bit, which turns straight binary into two's complement.

The serial side can run as a clock master or as a slave. As master it derives SCLK from the system clock and drives it out. In this mode a read-mode input decides whether a transfer starts when a conversion finishes, carrying the new word, or when the next conversion begins, carrying the word held from before. Only in the first case may a 2-bit divide setting slow SCLK. As slave it shifts on an SCLK from outside, and its serial input is passed through behind its own word, so several devices can share one data line. SCLK and SYNC can each be inverted. The conversion word and its done strobe arrive as plain inputs.

Top module: `result_port`

## Requirements
- R1: With port select `ser_sel_i` low, `pdata_oe_o` is all ones, and the clock edge that samples `conv_done_i` high loads the coded word that `pdata_o` shows; it is zero after reset.
- R2: With `swap_i` low, `pdata_o[7:0]` carries the coded word's low byte and `pdata_o[15:8]` its high byte; with `swap_i` high the two bytes trade places.
- R3: With `straight_i` high the word is passed unchanged; with it low, bit 15 is inverted. This coding applies to both the parallel and the serial path.
- R4: With `ser_sel_i` high, every bit of `pdata_oe_o` is low, bits 1:0 included. `sclk_oe_o` is high only in master mode (`ser_sel_i` high, `clk_src_i` low).
- R5: In master read-after-convert mode, the SCLK period is 2, 4, 8 or 16 system clocks for `div_i` equal to 0, 1, 2 or 3. In master read-during-convert mode it is always 2 clocks.
- R6: A serial transfer sends 16 bits, MSB first. Each bit changes on the inactive SCLK edge and is stable on the sampling edge, and SYNC is active on all 16 sampling edges.
- R7: SYNC is active high when `sync_inv_i` is low and active low when it is high. It is inactive whenever no result bits are being presented.
- R8: With `sclk_inv_i` low, the sampling edge is the rising edge and the master SCLK idles low. With it high, both are inverted, and this holds in master and slave mode alike.
- R9: In master mode with `rdmode_sdin_i` low, a transfer of the new word starts on `conv_done_i`, and `conv_start_i` alone starts nothing. With `rdmode_sdin_i` high, `conv_start_i` starts a transfer of the word held from the last `conv_done_i`, and `conv_done_i` alone starts nothing.
- R10: In slave mode (`clk_src_i` high), `conv_done_i` loads the word and the bits shift on the external `sclk_i`. The level taken from `rdmode_sdin_i` on the sampling edge of period k appears on `sdout_o` in period k+16, so a second device's word follows this one's on a shared line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| conv_start_i | input | 1 | Strobe: a conversion begins |
| conv_done_i | input | 1 | Strobe: result word is valid |
| result_i | input | 16 | Conversion word |
| ser_sel_i | input | 1 | 0 parallel bus, 1 serial port |
| swap_i | input | 1 | Exchange the bytes on the parallel bus |
| straight_i | input | 1 | 1 straight binary, 0 two's complement |
| clk_src_i | input | 1 | 0 internal SCLK (master), 1 external SCLK (slave) |
| sync_inv_i | input | 1 | 1 makes SYNC active low |
| sclk_inv_i | input | 1 | Inverts SCLK |
| rdmode_sdin_i | input | 1 | Master: read-mode select; slave: chained data in |
| div_i | input | 2 | Master SCLK divide setting |
| sclk_i | input | 1 | External SCLK |
| sclk_o | output | 1 | Generated SCLK |
| sclk_oe_o | output | 1 | Drive enable for `sclk_o` |
| sdout_o | output | 1 | Serial data out |
| sync_o | output | 1 | Frame signal |
| pdata_o | output | 16 | Parallel data |
| pdata_oe_o | output | 16 | Per-bit drive enable for `pdata_o` |

## Verification
The bench builds the block with its default 16-bit word and 2-bit divide setting. Under these values every swap and coding combination, all four divide ratios and every SCLK and SYNC polarity pair can be swept in full within a short run. Two instances share one external SCLK, and the upstream output is wired into the downstream serial input. This exposes the full 32-bit chained stream, so the 16-period pass-through delay can be measured bit by bit.

// File: rtl/rp_pkg.sv
package rp_pkg;
    // Which engine, if any, owns the serial shift register.
    typedef enum logic [1:0] {
        XFER_IDLE   = 2'd0,
        XFER_MASTER = 2'd1,
        XFER_SLAVE  = 2'd2
    } xfer_e;
endpackage

// File: rtl/rp_master_clk.sv
module rp_master_clk #(
    parameter int DIV_W = 2,
    localparam int CNT_W = 1 << DIV_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic [DIV_W-1:0] div_i,
    output logic             sclk_raw_o,
    output logic             rise_o,
    output logic             fall_o
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             raw;
    } mclk_t;

    mclk_t s_q, s_d;
    logic [CNT_W:0]   period_d;
    logic [CNT_W-1:0] half_m1_d, full_m1_d;

    always_comb begin
        period_d  = (CNT_W+1)'(2) << div_i;
        full_m1_d = CNT_W'(period_d - 1'b1);
        half_m1_d = CNT_W'((period_d >> 1) - 1'b1);
        rise_o    = run_i && (s_q.cnt == half_m1_d);
        fall_o    = run_i && (s_q.cnt == full_m1_d);
        s_d       = s_q;
        if (!run_i) begin
            s_d.cnt = '0;
            s_d.raw = 1'b0;
        end else if (fall_o) begin
            s_d.cnt = '0;
            s_d.raw = 1'b0;
        end else begin
            s_d.cnt = s_q.cnt + 1'b1;
            if (rise_o) s_d.raw = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign sclk_raw_o = s_q.raw;

    // R5
    rise_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |=> s_q.raw);
    // R5
    fall_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fall_o |=> !s_q.raw);
endmodule

// File: rtl/rp_slave_sync.sv
module rp_slave_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk_i,
    input  logic inv_i,
    output logic rise_o,
    output logic fall_o
);
    typedef struct packed {
        logic [1:0] sync;
        logic       prev;
    } ssync_t;

    ssync_t s_q, s_d;
    logic   raw_d;

    always_comb begin
        raw_d     = s_q.sync[1] ^ inv_i;
        s_d.sync  = {s_q.sync[0], sclk_i};
        s_d.prev  = raw_d;
        rise_o    = raw_d & ~s_q.prev;
        fall_o    = ~raw_d & s_q.prev;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end
endmodule

// File: rtl/rp_par_out.sv
module rp_par_out #(
    parameter int W = 16,
    localparam int HALF = W / 2
) (
    input  logic [W-1:0] word_i,
    input  logic         swap_i,
    input  logic         en_i,
    output logic [W-1:0] data_o,
    output logic [W-1:0] oe_o
);
    for (genvar g = 0; g < HALF; g++) begin : g_lane
        assign data_o[g]        = swap_i ? word_i[g + HALF] : word_i[g];
        assign data_o[g + HALF] = swap_i ? word_i[g]        : word_i[g + HALF];
        assign oe_o[g]          = en_i;
        assign oe_o[g + HALF]   = en_i;
    end
endmodule

// File: rtl/result_port.sv
module result_port #(
    parameter int W     = 16,
    parameter int DIV_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             conv_start_i,
    input  logic             conv_done_i,
    input  logic [W-1:0]     result_i,
    input  logic             ser_sel_i,
    input  logic             swap_i,
    input  logic             straight_i,
    input  logic             clk_src_i,
    input  logic             sync_inv_i,
    input  logic             sclk_inv_i,
    input  logic             rdmode_sdin_i,
    input  logic [DIV_W-1:0] div_i,
    input  logic             sclk_i,
    output logic             sclk_o,
    output logic             sclk_oe_o,
    output logic             sdout_o,
    output logic             sync_o,
    output logic [W-1:0]     pdata_o,
    output logic [W-1:0]     pdata_oe_o
);
    import rp_pkg::*;

    localparam int CW = $clog2(W + 1);

    typedef struct packed {
        xfer_e         mode;
        logic [CW-1:0] bits;
        logic [W-1:0]  sh;
        logic          sdin;
        logic [W-1:0]  held;
    } port_t;

    port_t s_q, s_d;

    logic             master_d, slave_d, shift_d, sample_d, sync_act_d;
    logic [W-1:0]     coded_d;
    logic [DIV_W-1:0] eff_div_d;
    logic             m_run, m_raw, m_rise, m_fall, s_rise, s_fall;

    assign master_d  = ser_sel_i & ~clk_src_i;
    assign slave_d   = ser_sel_i & clk_src_i;
    assign eff_div_d = (master_d & ~rdmode_sdin_i) ? div_i : '0;
    assign m_run     = (s_q.mode == XFER_MASTER);

    rp_master_clk #(.DIV_W(DIV_W)) u_mclk (
        .clk(clk), .rst_n(rst_n), .run_i(m_run), .div_i(eff_div_d),
        .sclk_raw_o(m_raw), .rise_o(m_rise), .fall_o(m_fall)
    );

    rp_slave_sync u_ssync (
        .clk(clk), .rst_n(rst_n), .sclk_i(sclk_i), .inv_i(sclk_inv_i),
        .rise_o(s_rise), .fall_o(s_fall)
    );

    rp_par_out #(.W(W)) u_par (
        .word_i(s_q.held), .swap_i(swap_i), .en_i(~ser_sel_i),
        .data_o(pdata_o), .oe_o(pdata_oe_o)
    );

    always_comb begin
        coded_d  = result_i ^ {~straight_i, {(W-1){1'b0}}};
        shift_d  = (s_q.mode == XFER_MASTER) ? m_fall :
                   (s_q.mode == XFER_SLAVE)  ? s_fall : 1'b0;
        sample_d = slave_d & s_rise;
        s_d      = s_q;

        if (conv_done_i) s_d.held = coded_d;
        if (sample_d)    s_d.sdin = rdmode_sdin_i;

        unique case (s_q.mode)
            XFER_MASTER, XFER_SLAVE: begin
                if (shift_d) begin
                    s_d.sh = {s_q.sh[W-2:0],
                              (s_q.mode == XFER_SLAVE) ? s_q.sdin : 1'b0};
                    if (s_q.bits != CW'(W)) s_d.bits = s_q.bits + 1'b1;
                    if (s_q.mode == XFER_MASTER && s_q.bits == CW'(W - 1))
                        s_d.mode = XFER_IDLE;
                end
            end
            default: ;
        endcase

        // Configuration no longer matches the running engine: drop it.
        if ((s_q.mode == XFER_MASTER && !master_d) ||
            (s_q.mode == XFER_SLAVE && !slave_d))
            s_d.mode = XFER_IDLE;

        if (master_d && s_q.mode == XFER_IDLE) begin
            if (rdmode_sdin_i && conv_start_i) begin
                s_d.mode = XFER_MASTER;
                s_d.bits = '0;
                s_d.sh   = s_q.held;
            end else if (!rdmode_sdin_i && conv_done_i) begin
                s_d.mode = XFER_MASTER;
                s_d.bits = '0;
                s_d.sh   = coded_d;
            end
        end

        if (slave_d && conv_done_i) begin
            s_d.mode = XFER_SLAVE;
            s_d.bits = '0;
            s_d.sh   = coded_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q      <= '0;
            s_q.mode <= XFER_IDLE;
        end else begin
            s_q <= s_d;
        end
    end

    assign sync_act_d = (s_q.mode != XFER_IDLE) && (s_q.bits < CW'(W));
    assign sync_o     = sync_act_d ^ sync_inv_i;
    assign sdout_o    = (s_q.mode != XFER_IDLE) & s_q.sh[W-1];
    assign sclk_o     = m_raw ^ sclk_inv_i;
    assign sclk_oe_o  = master_d;

    // R6
    bits_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.bits <= CW'(W));
    // R6
    bit_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_d && s_q.bits < CW'(W) && !conv_done_i &&
         ((s_q.mode == XFER_MASTER && master_d) ||
          (s_q.mode == XFER_SLAVE && slave_d)))
        |=> s_q.bits == $past(s_q.bits) + 1'b1);
    // R9
    master_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(s_q.mode == XFER_MASTER) |-> $past(conv_done_i || conv_start_i));
    // R3
    held_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(conv_done_i && straight_i) |-> s_q.held == $past(result_i));
endmodule

// File: tb/tb_result_port.sv
module tb_result_port;
    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic        rst_n, conv_start, conv_done, ser_sel, swap, straight;
    logic        clk_src, sync_inv, sclk_inv, rdmode, sclk_ext;
    logic [1:0]  div;
    logic [15:0] result, result_up;
    logic        sclk_o, sclk_oe, sdout, sync_o;
    logic [15:0] pdata, pdata_oe;
    logic        up_sclk, up_sclk_oe, sdout_up, up_sync;
    logic [15:0] up_pdata, up_pdata_oe;
    logic        dut_sdin;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    always @(posedge clk) cyc++;

    assign dut_sdin = clk_src ? sdout_up : rdmode;

    result_port dut (
        .clk(clk), .rst_n(rst_n), .conv_start_i(conv_start), .conv_done_i(conv_done),
        .result_i(result), .ser_sel_i(ser_sel), .swap_i(swap), .straight_i(straight),
        .clk_src_i(clk_src), .sync_inv_i(sync_inv), .sclk_inv_i(sclk_inv),
        .rdmode_sdin_i(dut_sdin), .div_i(div), .sclk_i(sclk_ext),
        .sclk_o(sclk_o), .sclk_oe_o(sclk_oe), .sdout_o(sdout), .sync_o(sync_o),
        .pdata_o(pdata), .pdata_oe_o(pdata_oe)
    );

    result_port dut_up (
        .clk(clk), .rst_n(rst_n), .conv_start_i(conv_start), .conv_done_i(conv_done),
        .result_i(result_up), .ser_sel_i(ser_sel), .swap_i(swap), .straight_i(straight),
        .clk_src_i(clk_src), .sync_inv_i(sync_inv), .sclk_inv_i(sclk_inv),
        .rdmode_sdin_i(1'b0), .div_i(div), .sclk_i(sclk_ext),
        .sclk_o(up_sclk), .sclk_oe_o(up_sclk_oe), .sdout_o(sdout_up), .sync_o(up_sync),
        .pdata_o(up_pdata), .pdata_oe_o(up_pdata_oe)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [15:0] code(input logic [15:0] v, input logic st);
        return v ^ (st ? 16'h0000 : 16'h8000);
    endfunction

    task automatic done_pulse(input logic [15:0] v, input logic [15:0] vu);
        @(negedge clk);
        result = v; result_up = vu; conv_done = 1'b1;
        @(negedge clk);
        conv_done = 1'b0;
    endtask

    task automatic master_xfer(input logic [15:0] exp, input int per, input string req);
        logic [15:0] got = '0;
        bit sync_ok = 1'b1;
        bit per_ok = 1'b1;
        int t_prev = 0;
        for (int i = 0; i < 16; i++) begin
            if (!sclk_inv) @(posedge sclk_o); else @(negedge sclk_o);
            #1;
            got = {got[14:0], sdout};
            if (sync_o !== ~sync_inv) sync_ok = 1'b0;
            if (i > 0 && (cyc - t_prev) != per) per_ok = 1'b0;
            t_prev = cyc;
        end
        chk(got == exp, req, "master word MSB first (R6)", got, exp);
        chk(sync_ok, "R7", "SYNC active on all sampling edges", sync_o, ~sync_inv);
        chk(per_ok, "R5", "SCLK period in clocks", per_ok, 1);
        repeat (per * 2 + 2) @(negedge clk);
        chk(sync_o == sync_inv, "R7", "SYNC inactive after frame", sync_o, sync_inv);
        chk(sclk_o == sclk_inv, "R8", "SCLK idle level", sclk_o, sclk_inv);
    endtask

    task automatic slave_xfer(input logic [15:0] expd, input logic [15:0] expu);
        logic [31:0] got = '0;
        logic [15:0] upg = '0;
        bit sync_ok = 1'b1;
        for (int i = 0; i < 32; i++) begin
            sclk_ext = ~sclk_inv;
            repeat (4) @(negedge clk);
            got = {got[30:0], sdout};
            if (i < 16) upg = {upg[14:0], sdout_up};
            if (sync_o !== ((i < 16) ? ~sync_inv : sync_inv)) sync_ok = 1'b0;
            sclk_ext = sclk_inv;
            repeat (4) @(negedge clk);
        end
        chk(got[31:16] == expd, "R10", "slave own word", got[31:16], expd);
        chk(upg == expu, "R10", "upstream word", upg, expu);
        chk(got[15:0] == expu, "R10", "daisy chain pass-through after 16 periods", got[15:0], expu);
        chk(sync_ok, "R7", "slave SYNC framing (R8 inverted clock)", sync_ok, 1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [15:0] vals [5];
        logic [15:0] c, e;
        vals[0] = 16'h0000; vals[1] = 16'hFFFF; vals[2] = 16'h1234;
        vals[3] = 16'h8001; vals[4] = 16'h7F80;
        rst_n = 1'b0; conv_start = 1'b0; conv_done = 1'b0; ser_sel = 1'b0;
        swap = 1'b0; straight = 1'b1; clk_src = 1'b0; sync_inv = 1'b0;
        sclk_inv = 1'b0; rdmode = 1'b0; sclk_ext = 1'b0; div = 2'd0;
        result = '0; result_up = '0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(pdata == 16'h0 && pdata_oe == 16'hFFFF, "R1", "reset parallel state", pdata, 0);
        chk(sync_o == 1'b0 && sclk_oe == 1'b0, "R7", "reset SYNC/SCLK enable", {sync_o, sclk_oe}, 0);

        // R1 R2 R3: parallel sweep
        for (int sw = 0; sw < 2; sw++)
            for (int st = 0; st < 2; st++)
                for (int k = 0; k < 5; k++) begin
                    @(negedge clk);
                    swap = sw[0]; straight = st[0];
                    done_pulse(vals[k], 16'h0);
                    c = code(vals[k], st[0]);
                    e = sw[0] ? {c[7:0], c[15:8]} : c;
                    chk(pdata == e, "R2", "parallel data swap/coding (R3)", pdata, e);
                    chk(pdata_oe == 16'hFFFF, "R1", "parallel drivers on", pdata_oe, 16'hFFFF);
                end

        // Serial master: read after convert
        @(negedge clk);
        ser_sel = 1'b1; swap = 1'b0;
        @(negedge clk);
        chk(pdata_oe == 16'h0, "R4", "parallel drivers off in serial", pdata_oe, 0);
        chk(sclk_oe == 1'b1, "R4", "SCLK driven in master", sclk_oe, 1);
        for (int iv = 0; iv < 2; iv++)
            for (int si = 0; si < 2; si++)
                for (int d = 0; d < 4; d++) begin
                    @(negedge clk);
                    sclk_inv = iv[0]; sync_inv = si[0]; div = d[1:0];
                    straight = d[0];
                    repeat (3) @(negedge clk);
                    chk(sclk_o == iv[0], "R8", "master SCLK idle", sclk_o, iv[0]);
                    c = 16'hA5C3 ^ 16'(d * 16'h1111 + iv * 16'h0F0F + si * 16'h3003);
                    done_pulse(c, 16'h0);
                    master_xfer(code(c, d[0]), 2 << d, "R9");
                end

        // R9: start-only in read-after-convert does nothing
        @(negedge clk);
        sclk_inv = 1'b0; sync_inv = 1'b0; div = 2'd3; straight = 1'b1;
        conv_start = 1'b1;
        @(negedge clk);
        conv_start = 1'b0;
        repeat (40) @(negedge clk);
        chk(sync_o == 1'b0 && sclk_o == 1'b0, "R9", "start ignored after-convert mode", {sync_o, sclk_o}, 0);

        // R9: read during convert, divide ignored (R5)
        rdmode = 1'b1;
        done_pulse(16'h9C3E, 16'h0);
        repeat (40) @(negedge clk);
        chk(sync_o == 1'b0 && sclk_o == 1'b0, "R9", "done ignored during-convert mode", {sync_o, sclk_o}, 0);
        @(negedge clk);
        conv_start = 1'b1;
        @(negedge clk);
        conv_start = 1'b0;
        master_xfer(16'h9C3E, 2, "R9");

        // Slave with daisy chain
        @(negedge clk);
        rdmode = 1'b0; clk_src = 1'b1; div = 2'd0;
        @(negedge clk);
        chk(sclk_oe == 1'b0, "R4", "SCLK not driven in slave", sclk_oe, 0);
        chk(pdata_oe == 16'h0, "R4", "parallel drivers off in slave", pdata_oe, 0);
        for (int iv = 0; iv < 2; iv++)
            for (int si = 0; si < 2; si++) begin
                @(negedge clk);
                sclk_inv = iv[0]; sync_inv = si[0]; straight = si[0];
                sclk_ext = iv[0];
                repeat (6) @(negedge clk);
                c = 16'h5A1F + 16'(iv * 16'h2222);
                e = 16'hC036 ^ 16'(si * 16'h0505);
                done_pulse(c, e);
                slave_xfer(code(c, si[0]), code(e, si[0]));
            end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule